// File: doc/BRIEF.md
# Programmable Wake-Up Timer with Duty-Cycle Window

This block produces a periodic wake-up event for a low-power radio controller. A slow time base arrives as a one-cycle `tick` strobe, one per millisecond. The block counts these ticks. When a programmed period has elapsed, it emits a single-cycle `wake_o` pulse and begins the next period at once.

The period is a mantissa multiplied by a power of two. Both fields sit in a 16-bit timer command word, which is accepted only if its top three bits carry a fixed prefix. The command is captured only on a rising edge of the timer enable, so restarting with a new setting means dropping the enable and raising it again.

Each wake-up also sets a sticky overflow flag. The flag stays set until a status read clears it. A second command word can open a receive-enable window during the first part of every period. The window's length is an odd multiple of the same power-of-two unit, so its share of the period is (2·D+1)/M.

Top module: `wake_timer`

## Requirements
- R1: The timer command word is laid out as follows. Bits [7:0] hold the mantissa M, bits [12:8] hold the exponent E, and bits [15:13] must be 3'b111. Once enabled with tick high every cycle, the timer fires its first `wake_o` exactly M·2^E ticks after the enable rising edge. The tick seen on the edge that detects the rise is not counted.
- R2: `wake_o` is high for one clock per event. The count then restarts from zero, so events repeat every M·2^E ticks while `tmr_en` stays high. Clock cycles without `tick` do not advance the count. With `tmr_en` low, no event occurs.
- R3: `ovf_flag` rises in the same cycle as each `wake_o` pulse. It stays set until a cycle with `stat_rd` high, after which it reads low. If a read and a new event fall on the same edge, the flag stays set.
- R4: The duty command carries the enable in bit 0 and D in bits [7:1]. When the enable is 1, `duty_on` is high during the first (2·D+1)·2^E ticks of every period, or for the whole period if 2·D+1 ≥ M. It is low when the duty enable is 0 or when the timer is not running.
- R5: When the captured M is zero, the timer produces no `wake_o` and `duty_on` stays low.
- R6: The timer command is captured only on a rising edge of `tmr_en`. Changing it while the timer runs has no effect until the enable is dropped and raised again.
- R7: A command without the 3'b111 prefix is rejected at the enable rising edge, and the previous setting is kept. After reset the setting equals 16'hE196, that is M=150 and E=1, a period of 300 ticks.
- R8: During and after reset, `wake_o`, `ovf_flag` and `duty_on` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per millisecond of the slow time base |
| tmr_cmd | input | 16 | Timer command word: prefix, exponent, mantissa |
| duty_cmd | input | 8 | Duty command: D in [7:1], window enable in [0] |
| tmr_en | input | 1 | Timer enable; a rising edge captures the command and restarts |
| stat_rd | input | 1 | Status read strobe; clears the overflow flag |
| wake_o | output | 1 | One-cycle wake-up pulse |
| ovf_flag | output | 1 | Sticky wake-up overflow status |
| duty_on | output | 1 | Low-duty-cycle receive enable |

## Verification
The assertions check several rules on every cycle:
- no pulse follows a cycle without a tick or without the enable;
- the overflow flag only rises together with a wake-up;
- a read without a coinciding event leaves the flag low;
- a zero mantissa silences both outputs.

Other behaviours only the bench scenarios can show. These are the exact period length for several mantissa and exponent pairs, the width of the duty window including the clamp to the full period, rejection of a command without the prefix, and the power-on setting. They also include the rule that a command written mid-run waits for the next enable edge, and the set-wins case when a read meets a wake-up.

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int          MANT_W    = 8,
  parameter int          EXP_W     = 5,
  parameter int          DUTY_W    = 7,
  parameter int          PFX_W     = 3,
  parameter logic [2:0]  PFX       = 3'b111,
  parameter logic [15:0] RESET_CMD = 16'hE196
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick,
  input  logic [PFX_W+EXP_W+MANT_W-1:0]     tmr_cmd,
  input  logic [DUTY_W:0]                   duty_cmd,
  input  logic                              tmr_en,
  input  logic                              stat_rd,
  output logic                              wake_o,
  output logic                              ovf_flag,
  output logic                              duty_on
);
  localparam int CMD_W = PFX_W + EXP_W + MANT_W;
  localparam int CNT_W = MANT_W + (1 << EXP_W) - 1;

  logic [MANT_W-1:0] m_q;
  logic [EXP_W-1:0]  e_q;
  logic              en_q, run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  period, on_len;
  logic              rise, cmd_ok, last, m_zero;

  assign rise   = tmr_en & ~en_q;
  assign cmd_ok = tmr_cmd[CMD_W-1 -: PFX_W] == PFX[PFX_W-1:0];
  assign m_zero = m_q == '0;
  assign period = CNT_W'(m_q) << e_q;
  assign on_len = CNT_W'({duty_cmd[DUTY_W:1], 1'b1}) << e_q;
  assign last   = run_q & tick & ~m_zero & (cnt_q == period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= RESET_CMD[MANT_W-1:0];
      e_q <= RESET_CMD[MANT_W +: EXP_W];
    end else if (rise && cmd_ok) begin
      m_q <= tmr_cmd[MANT_W-1:0];
      e_q <= tmr_cmd[MANT_W +: EXP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= tmr_en;
      if (!tmr_en) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (rise) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (last) begin
        cnt_q <= '0;
      end else if (run_q && tick && !m_zero) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_o   <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      wake_o <= last & tmr_en & ~rise;
      if (last && tmr_en && !rise) ovf_flag <= 1'b1;
      else if (stat_rd)            ovf_flag <= 1'b0;
    end
  end

  assign duty_on = run_q & duty_cmd[0] & ~m_zero & (cnt_q < on_len);
endmodule

module wake_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       tmr_en,
  input logic       stat_rd,
  input logic       wake_o,
  input logic       ovf_flag,
  input logic       duty_on,
  input logic [7:0] m_q
);
  p_no_tick_no_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !wake_o);
  p_off_no_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> !wake_o);
  p_ovf_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> wake_o);
  p_wake_sets_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ovf_flag);
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_o && $past(stat_rd)) |-> !ovf_flag);
  p_off_no_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> !duty_on);
  p_zero_mant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q == 8'd0) |-> (!wake_o && !duty_on));
endmodule

bind wake_timer wake_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tmr_en(tmr_en), .stat_rd(stat_rd),
  .wake_o(wake_o), .ovf_flag(ovf_flag), .duty_on(duty_on), .m_q(m_q)
);

// File: tb/test_wake_timer.sv
module test_wake_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, tmr_en = 1'b0, stat_rd = 1'b0;
  logic [15:0] tmr_cmd = 16'h0;
  logic [7:0]  duty_cmd = 8'h0;
  logic wake_o, ovf_flag, duty_on;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wake_timer i_wake_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tmr_cmd(tmr_cmd), .duty_cmd(duty_cmd),
    .tmr_en(tmr_en), .stat_rd(stat_rd), .wake_o(wake_o), .ovf_flag(ovf_flag),
    .duty_on(duty_on)
  );

  // {M, E, D, duty_en, period, duty-high count}
  localparam logic [47:0] VEC [6] = '{
    {8'd3, 8'd0, 8'd0, 8'd1, 8'd3,  8'd1},
    {8'd5, 8'd1, 8'd1, 8'd1, 8'd10, 8'd6},
    {8'd4, 8'd2, 8'd1, 8'd1, 8'd16, 8'd12},
    {8'd2, 8'd0, 8'd5, 8'd1, 8'd2,  8'd2},
    {8'd7, 8'd0, 8'd2, 8'd0, 8'd7,  8'd0},
    {8'd1, 8'd3, 8'd0, 8'd1, 8'd8,  8'd8}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic restart(input logic [15:0] cmd);
    tmr_en = 1'b0;
    @(negedge clk);
    tmr_cmd = cmd;
    @(negedge clk);
    tmr_en = 1'b1;
  endtask

  // returns index of first wake within limit, -1 if none
  task automatic first_wake(input int limit, output int idx);
    idx = -1;
    for (int j = 0; j <= limit; j++) begin
      @(negedge clk);
      if (wake_o && idx < 0) idx = j;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int idx, wakes, werr, dcnt;
    repeat (3) @(negedge clk);
    check(!wake_o && !ovf_flag && !duty_on, "R8 reset outputs", {wake_o, ovf_flag, duty_on}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wake_o && !ovf_flag && !duty_on, "R8 after reset", {wake_o, ovf_flag, duty_on}, 0);

    // R7: power-on setting used when command prefix invalid
    tick = 1'b1; duty_cmd = 8'h00;
    restart(16'h0103);
    first_wake(300, idx);
    check(idx == 300, "R7 power-on period", idx, 300);

    // vector table: R1 R2 R4
    for (int v = 0; v < 6; v++) begin
      logic [7:0] m, e, d, den, per, on;
      {m, e, d, den, per, on} = VEC[v];
      duty_cmd = {d[6:0], den[0]};
      restart({3'b111, e[4:0], m});
      werr = 0; wakes = 0; dcnt = 0;
      for (int j = 0; j <= 2 * per; j++) begin
        @(negedge clk);
        if (wake_o !== (j == per || j == 2 * per)) werr++;
        if (wake_o) wakes++;
        if (j < per && duty_on) dcnt++;
      end
      check(werr == 0, "R1 period placement", werr, 0);
      check(wakes == 2, "R2 repeated wakes", wakes, 2);
      check(dcnt == on, "R4 duty window", dcnt, on);
    end

    // R7: invalid prefix keeps previous valid setting
    restart({3'b111, 5'd0, 8'd4});
    first_wake(4, idx);
    check(idx == 4, "R7 valid setting", idx, 4);
    restart(16'h6005);
    first_wake(5, idx);
    check(idx == 4, "R7 rejected prefix", idx, 4);

    // R6: mid-run command change ignored until re-enable
    restart({3'b111, 5'd0, 8'd3});
    @(negedge clk);
    tmr_cmd = {3'b111, 5'd0, 8'd6};
    werr = 0;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      if (wake_o !== (j == 3 || j == 6)) werr++;
    end
    check(werr == 0, "R6 change ignored while running", werr, 0);
    restart({3'b111, 5'd0, 8'd6});
    first_wake(6, idx);
    check(idx == 6, "R6 new setting after re-enable", idx, 6);

    // R3: read clears, set wins over simultaneous read
    tmr_en = 1'b0;
    @(negedge clk);
    check(ovf_flag == 1'b1, "R3 sticky flag", ovf_flag, 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check(ovf_flag == 1'b0, "R3 read clears", ovf_flag, 0);
    restart({3'b111, 5'd0, 8'd3});
    for (int j = 0; j <= 5; j++) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check(wake_o && ovf_flag, "R3 set wins over read", {wake_o, ovf_flag}, 3);

    // R2: no tick, no progress; enable low, no wake
    restart({3'b111, 5'd0, 8'd2});
    tick = 1'b0;
    wakes = 0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (wake_o) wakes++;
    end
    check(wakes == 0, "R2 no wake without tick", wakes, 0);
    tick = 1'b1;
    @(negedge clk);
    check(!wake_o, "R2 first tick counted", wake_o, 0);
    @(negedge clk);
    check(wake_o, "R2 wake after two ticks", wake_o, 1);
    tmr_en = 1'b0;
    duty_cmd = 8'h01;
    @(negedge clk);
    wakes = 0; dcnt = 0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (wake_o) wakes++;
      if (duty_on) dcnt++;
    end
    check(wakes == 0, "R2 disabled no wake", wakes, 0);
    check(dcnt == 0, "R4 disabled no duty", dcnt, 0);

    // R5: zero mantissa
    restart(16'hE000);
    wakes = 0; dcnt = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (wake_o) wakes++;
      if (duty_on) dcnt++;
    end
    check(wakes == 0 && dcnt == 0, "R5 zero mantissa silent", wakes + dcnt, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule